// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block lets a host run short, arbitrary commands on a serial flash through a few byte-wide registers. The host pushes an opcode and then its payload bytes into a transmit queue. It writes a length word that packs the payload count and the response count into two nibbles. It then sets a start bit in the control register. The engine lowers chip select and shifts the queued bytes out MSB first in SPI mode 0. It clocks in the requested number of response bytes, raises chip select and clears the start bit. The host polls that bit to learn when the transfer has finished, and then pops the captured bytes one at a time.

A lock register guards the command registers. Until the host writes the unlock key, writes to the queue, the length word and the control register are dropped. Writes to those registers while a transfer is running are dropped too. Reads are always served.

The register bus is a single-cycle valid/write/address/data port. Read data is combinational from the address. A read of the receive-data address pops the receive buffer on the clock edge that ends the access.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK and MOSI are low, the block is locked, and reads return 0x00 from the control, lock, length and queue-count addresses and 0xFF from the receive-data address.
- R2: Writing 0x10 to address 0xB3 unlocks the block and writing 0x00 locks it. Any other value leaves the lock state unchanged. Address 0xB3 reads 0x10 when unlocked and 0x00 when locked.
- R3: While the block is locked, or while a transfer is running, writes to 0x90, 0x92 and 0x93 have no effect: the queue count, the length word and the SPI pins keep their values.
- R4: Each write to 0x90 appends one byte to the transmit queue. The first byte pushed is the opcode. The queue holds 16 bytes and further pushes are dropped. Reading 0x90 returns the number of queued bytes.
- R5: Setting bit 0 of 0x93 starts a transfer. The transfer sends (bits 3:0 of 0x92) + 1 bytes from the queue in push order, each MSB first. MOSI changes only while SCK is low.
- R6: SCK idles low, and every high phase of SCK lasts CLK_DIV system clocks.
- R7: Chip select falls once at the start of a transfer and rises once after the last bit. While it is low, SCK gives exactly 8 × (write bytes + read bytes) rising edges, where the read count is (bits 7:4 of 0x92) + 1. SCK is low whenever chip select is high.
- R8: When bit 2 of the triggering control write is set, the read nibble is ignored: no read bytes are clocked and chip select rises after the last write byte.
- R9: MISO is sampled on SCK rising edges. Response bytes are stored in order of reception. Each read of 0x91 returns the next stored byte and advances the read pointer. Once all stored bytes have been read, 0x91 returns 0xFF.
- R10: Bit 0 of 0x93 reads 1 while a transfer runs and 0 once it is done. Completion resets the queue count to 0.
- R11: Writing a control value with bit 1 set empties the transmit queue and discards all stored response bytes.
- R12: When bit 3 of the triggering control write is set, the bytes received during the write phase are stored as well, ahead of the read-phase bytes, up to 16 bytes in total.
- R13: MOSI is driven low during the read phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe, one access per cycle |
| reg_write | input | 1 | 1 = write access, 0 = read access |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check on every cycle that SCK stays low while chip select is high, that MOSI holds steady through each SCK high phase, and that a byte start never hits a busy shifter. They also check that the queue count, capture count and read pointer stay within their bounds, and that a locked push never changes the queue count. Only the bench scenarios can show the other behaviours. These are the byte order and the exact bit count of each command, the response order when readback is on or off, the 0xFF returned after the buffer is drained, and that register writes made while locked or busy are really dropped. The bench sweeps every write length from 1 to 16 against short, full and suppressed read phases, and compares every bit on the wire with values it computes from the lengths and its own data pattern.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam logic [7:0] ADDR_TXQ  = 8'h90;
    localparam logic [7:0] ADDR_RXD  = 8'h91;
    localparam logic [7:0] ADDR_LEN  = 8'h92;
    localparam logic [7:0] ADDR_CTL  = 8'h93;
    localparam logic [7:0] ADDR_LOCK = 8'hB3;

    localparam logic [7:0] KEY_OPEN = 8'h10;
    localparam logic [7:0] KEY_SHUT = 8'h00;

    localparam int CTL_GO       = 0;
    localparam int CTL_CLEAR    = 1;
    localparam int CTL_NOREAD   = 2;
    localparam int CTL_READBACK = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;
endpackage

// File: rtl/spi_eng_bytebuf.sv
module spi_eng_bytebuf #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
    parameter int CLK_DIV = 2,
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic             busy;
        logic [DIV_W-1:0] div;
        logic [2:0]       bitn;
        logic             sck;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.div  = '0;
                s_d.bitn = '0;
                s_d.sck  = 1'b0;
                s_d.sh   = tx_byte;
            end
        end else if (s_q.div == DIV_W'(CLK_DIV - 1)) begin
            s_d.div = '0;
            if (!s_q.sck) begin
                s_d.sck = 1'b1;
                s_d.rx  = {s_q.rx[6:0], miso};
            end else begin
                s_d.sck = 1'b0;
                if (s_q.bitn == 3'd7) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.bitn = s_q.bitn + 3'd1;
                    s_d.sh   = {s_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            s_d.div = s_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sck     = s_q.sck;
    assign mosi    = s_q.busy & s_q.sh[7];
    assign done    = s_q.done;
    assign rx_byte = s_q.rx;

    // R5: data launched on the falling edge stays put through the high phase
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sck |-> $stable(mosi));

    // R7: the sequencer never starts a byte on top of one in flight
    p_start_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_valid,
    input  logic       reg_write,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int IDX_W = PTR_W + 2;
    localparam int NIB_W = PTR_W;

    typedef struct packed {
        seq_st_e          st;
        logic             unlocked;
        logic [7:0]       len;
        logic             noread;
        logic             readback;
        logic [CNT_W-1:0] wr_cnt;
        logic [CNT_W-1:0] cap_cnt;
        logic [CNT_W-1:0] rd_ptr;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] tot;
        logic [CNT_W-1:0] wlen;
        logic             cs_n;
        logic             start;
    } eng_t;

    eng_t s_d, s_q;

    logic             is_wr, is_rd, cmd_ok;
    logic [CNT_W-1:0] wcount, rcount;
    logic             txq_we, rxb_we;
    logic [PTR_W-1:0] txq_waddr, rxb_waddr;
    logic [7:0]       txq_rdata, rxb_rdata, tx_byte, rx_byte;
    logic             sh_done;

    assign is_wr  = reg_valid & reg_write;
    assign is_rd  = reg_valid & ~reg_write;
    assign cmd_ok = s_q.unlocked & (s_q.st == ST_IDLE);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        txq_we    = 1'b0;
        txq_waddr = s_q.wr_cnt[PTR_W-1:0];
        rxb_we    = 1'b0;
        rxb_waddr = s_q.cap_cnt[PTR_W-1:0];
        wcount    = CNT_W'(s_q.len[NIB_W-1:0]) + CNT_W'(1);
        rcount    = reg_wdata[CTL_NOREAD] ? '0
                  : CNT_W'(s_q.len[2*NIB_W-1:NIB_W]) + CNT_W'(1);

        if (is_wr && reg_addr == ADDR_LOCK) begin
            if (reg_wdata == KEY_OPEN) begin
                s_d.unlocked = 1'b1;
            end else if (reg_wdata == KEY_SHUT) begin
                s_d.unlocked = 1'b0;
            end
        end

        if (is_wr && cmd_ok && reg_addr == ADDR_TXQ
                && s_q.wr_cnt < CNT_W'(DEPTH)) begin
            txq_we     = 1'b1;
            s_d.wr_cnt = s_q.wr_cnt + CNT_W'(1);
        end

        if (is_wr && cmd_ok && reg_addr == ADDR_LEN) begin
            s_d.len = reg_wdata;
        end

        if (is_wr && cmd_ok && reg_addr == ADDR_CTL) begin
            s_d.noread   = reg_wdata[CTL_NOREAD];
            s_d.readback = reg_wdata[CTL_READBACK];
            if (reg_wdata[CTL_CLEAR]) begin
                s_d.wr_cnt  = '0;
                s_d.cap_cnt = '0;
                s_d.rd_ptr  = '0;
            end
            if (reg_wdata[CTL_GO]) begin
                s_d.st      = ST_RUN;
                s_d.cs_n    = 1'b0;
                s_d.start   = 1'b1;
                s_d.idx     = '0;
                s_d.cap_cnt = '0;
                s_d.rd_ptr  = '0;
                s_d.wlen    = wcount;
                s_d.tot     = IDX_W'(wcount) + IDX_W'(rcount);
            end
        end

        if (is_rd && reg_addr == ADDR_RXD && s_q.rd_ptr < s_q.cap_cnt) begin
            s_d.rd_ptr = s_q.rd_ptr + CNT_W'(1);
        end

        if (s_q.st == ST_RUN && sh_done) begin
            if ((s_q.idx >= IDX_W'(s_q.wlen) || s_q.readback)
                    && s_q.cap_cnt < CNT_W'(DEPTH)) begin
                rxb_we      = 1'b1;
                s_d.cap_cnt = s_q.cap_cnt + CNT_W'(1);
            end
            if (s_q.idx + IDX_W'(1) == s_q.tot) begin
                s_d.st     = ST_IDLE;
                s_d.cs_n   = 1'b1;
                s_d.wr_cnt = '0;
            end else begin
                s_d.idx   = s_q.idx + IDX_W'(1);
                s_d.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_TXQ:  reg_rdata = 8'(s_q.wr_cnt);
            ADDR_RXD:  reg_rdata = (s_q.rd_ptr < s_q.cap_cnt) ? rxb_rdata : 8'hFF;
            ADDR_LEN:  reg_rdata = s_q.len;
            ADDR_CTL:  reg_rdata = {4'b0, s_q.readback, s_q.noread, 1'b0,
                                    s_q.st == ST_RUN};
            ADDR_LOCK: reg_rdata = s_q.unlocked ? KEY_OPEN : KEY_SHUT;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign tx_byte = (s_q.idx < IDX_W'(s_q.wlen)) ? txq_rdata : 8'h00;

    spi_eng_bytebuf #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .we(txq_we), .waddr(txq_waddr),
        .wdata(reg_wdata), .raddr(s_q.idx[PTR_W-1:0]), .rdata(txq_rdata)
    );

    spi_eng_bytebuf #(.DEPTH(DEPTH)) u_rxb (
        .clk(clk), .rst_n(rst_n), .we(rxb_we), .waddr(rxb_waddr),
        .wdata(rx_byte), .raddr(s_q.rd_ptr[PTR_W-1:0]), .rdata(rxb_rdata)
    );

    spi_eng_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(s_q.start), .tx_byte(tx_byte),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done),
        .rx_byte(rx_byte)
    );

    assign spi_cs_n = s_q.cs_n;

    // R7: the serial clock is parked low whenever the flash is deselected
    p_sck_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R3: a locked push in idle leaves the queue count untouched
    p_locked_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.unlocked && s_q.st == ST_IDLE && is_wr && reg_addr == ADDR_TXQ)
        |=> s_d.wr_cnt == s_q.wr_cnt || s_q.wr_cnt == $past(s_q.wr_cnt));

    // R4: queue count never exceeds its depth
    p_queue_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr_cnt <= CNT_W'(DEPTH));

    // R12: capture never exceeds the buffer
    p_cap_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cap_cnt <= CNT_W'(DEPTH));

    // R9: the host can never pop past what was captured
    p_pop_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_ptr <= s_q.cap_cnt);

    // R10: a finished byte only ever arrives during a transfer
    p_done_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |-> s_q.st == ST_RUN);
endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
    localparam int DIV   = 2;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_valid = 1'b0;
    logic       reg_write = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    spi_cmd_engine #(.DEPTH(DEPTH), .CLK_DIV(DIV)) u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Line monitor
    int           rises = 0, cs_falls = 0, cs_rises = 0, bad_hi = 0, bad_mosi = 0;
    int           hi_run = 0;
    logic [255:0] mosi_sh = '0;
    logic         p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    int           run_base = 0;
    int           seed = 3;
    logic [7:0]   txb [16];

    function automatic logic [7:0] resp_byte(input int j);
        return 8'((j * 29 + seed) ^ 8'h5A);
    endfunction

    always_comb begin
        int k;
        logic [7:0] b;
        k = rises - run_base;
        b = resp_byte(k / 8);
        spi_miso = b[7 - (k % 8)];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && p_cs) cs_falls++;
            if (spi_cs_n && !p_cs) cs_rises++;
            if (!spi_cs_n && spi_sck && !p_sck) begin
                rises++;
                mosi_sh = {mosi_sh[254:0], spi_mosi};
            end
            if (spi_sck && p_sck && spi_mosi != p_mosi) bad_mosi++;
            if (spi_sck) hi_run++;
            else if (p_sck) begin
                if (hi_run != DIV) bad_hi++;
                hi_run = 0;
            end
            p_sck  = spi_sck;
            p_cs   = spi_cs_n;
            p_mosi = spi_mosi;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic run_cmd(input int w, input int r, input bit nr, input bit rb);
        logic [7:0] v, len_w, got;
        int b_r, b_f, b_rs, b_h, b_m, nbits, nbytes, ncap, polls;
        seed = seed + 7;
        reg_wr(8'h93, 8'h02);
        for (int i = 0; i < w; i++) begin
            txb[i] = 8'(i * 53 + seed + 1);
            reg_wr(8'h90, txb[i]);
        end
        if (w == 16) begin
            reg_wr(8'h90, 8'hC3);
            reg_rd(8'h90, v);
            chk("R4 queue caps at 16", int'(v), 16);
        end
        len_w = {4'(r - 1), 4'(w - 1)};
        reg_wr(8'h92, len_w);
        b_r = rises; b_f = cs_falls; b_rs = cs_rises; b_h = bad_hi; b_m = bad_mosi;
        run_base = rises;
        reg_wr(8'h93, {4'b0, rb, nr, 1'b0, 1'b1});
        reg_rd(8'h93, v);
        chk("R10 busy bit set", int'(v[0]), 1);
        if (w == 8 && !nr) begin
            reg_wr(8'h92, 8'hEE);
            reg_wr(8'h90, 8'h77);
        end
        polls = 0;
        do begin
            reg_rd(8'h93, v);
            polls++;
        end while (v[0] && polls < 3000);
        chk("R10 busy bit clears", int'(v[0]), 0);
        if (w == 8 && !nr) begin
            reg_rd(8'h92, v);
            chk("R3 length write while busy dropped", int'(v), int'(len_w));
        end
        nbytes = w + (nr ? 0 : r);
        nbits  = 8 * nbytes;
        chk(nr ? "R8 bit count no-read" : "R7 bit count", rises - b_r, nbits);
        chk("R7 one cs fall", cs_falls - b_f, 1);
        chk("R7 one cs rise", cs_rises - b_rs, 1);
        chk("R6 sck high phase", bad_hi - b_h, 0);
        chk("R5 mosi stable while sck high", bad_mosi - b_m, 0);
        for (int b = 0; b < nbytes; b++) begin
            for (int k = 0; k < 8; k++) got[7 - k] = mosi_sh[nbits - 1 - (8 * b + k)];
            if (b < w) chk("R5 write byte", int'(got), int'(txb[b]));
            else       chk("R13 mosi low in read phase", int'(got), 0);
        end
        if (rb) ncap = (nbytes > 16) ? 16 : nbytes;
        else    ncap = nr ? 0 : r;
        for (int i = 0; i < ncap; i++) begin
            reg_rd(8'h91, v);
            if (rb) chk("R12 readback byte", int'(v), int'(resp_byte(i)));
            else    chk("R9 read byte", int'(v), int'(resp_byte(w + i)));
        end
        reg_rd(8'h91, v);
        chk("R9 drained reads 0xFF", int'(v), 8'hFF);
        reg_rd(8'h90, v);
        chk("R10 queue empty after completion", int'(v), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 cs_n high", int'(spi_cs_n), 1);
        chk("R1 sck low", int'(spi_sck), 0);
        chk("R1 mosi low", int'(spi_mosi), 0);
        reg_rd(8'h93, v); chk("R1 control", int'(v), 0);
        reg_rd(8'hB3, v); chk("R1 lock", int'(v), 0);
        reg_rd(8'h92, v); chk("R1 length", int'(v), 0);
        reg_rd(8'h90, v); chk("R1 queue count", int'(v), 0);
        reg_rd(8'h91, v); chk("R1 rx empty", int'(v), 8'hFF);

        // locked: command registers ignore writes
        reg_wr(8'h92, 8'h5A);
        reg_rd(8'h92, v); chk("R3 locked length", int'(v), 0);
        reg_wr(8'h90, 8'h9F);
        reg_rd(8'h90, v); chk("R3 locked push", int'(v), 0);
        reg_wr(8'h93, 8'h01);
        repeat (10) @(negedge clk);
        chk("R3 locked trigger cs", int'(spi_cs_n), 1);
        chk("R3 locked trigger falls", cs_falls, 0);
        reg_rd(8'h93, v); chk("R3 locked trigger busy", int'(v), 0);

        // lock key handling
        reg_wr(8'hB3, 8'h33);
        reg_rd(8'hB3, v); chk("R2 bad key keeps lock", int'(v), 0);
        reg_wr(8'hB3, 8'h10);
        reg_rd(8'hB3, v); chk("R2 unlock", int'(v), 8'h10);
        reg_wr(8'hB3, 8'h33);
        reg_rd(8'hB3, v); chk("R2 bad key keeps unlock", int'(v), 8'h10);

        // sweep all write lengths against read shapes
        for (int w = 1; w <= 16; w++) begin
            run_cmd(w, 1, 1'b0, (w % 5) == 0);
            run_cmd(w, 16, 1'b0, 1'b0);
            run_cmd(w, w, 1'b1, 1'b0);
        end
        run_cmd(16, 16, 1'b0, 1'b1);
        run_cmd(3, 4, 1'b1, 1'b1);

        // clear bit drops captured data and queued bytes
        run_cmd(2, 4, 1'b0, 1'b0);
        reg_wr(8'h90, 8'h01);
        reg_wr(8'h90, 8'h02);
        reg_wr(8'h90, 8'h03);
        reg_rd(8'h90, v); chk("R4 queue count", int'(v), 3);
        reg_wr(8'h93, 8'h02);
        reg_rd(8'h90, v); chk("R11 clear empties queue", int'(v), 0);
        reg_rd(8'h91, v); chk("R11 clear empties rx", int'(v), 8'hFF);

        // relock
        reg_wr(8'hB3, 8'h00);
        reg_rd(8'hB3, v); chk("R2 relock", int'(v), 0);
        reg_wr(8'h92, 8'h11);
        reg_rd(8'h92, v); chk("R3 relocked length", int'(v), 8'h31);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule